// File: doc/BRIEF.md
# Write-Intensity Tracking Queue

This block watches the write hits of a cache and keeps a short, fully associative list of the block addresses that were written recently, each with a small hit count. A write hit to a listed address raises that address's count. A write hit to an unlisted address claims a free slot. When no slot is free, it takes the slot used least recently. Counts fade over time: whenever the free-running cycle count passes a moving deadline, every live count drops by one, and a slot whose count falls to zero is free again.

When a write pushes a count up to the threshold, the address is judged write intensive. The block then pulses a migration request carrying that address, asking the cache to swap the block into its fast-write region. If the cache reports that the block already sits in the fast region, no request goes out. In both cases the slot is released, so the same address cannot fire again on every later write. Read hits are accepted on the port and never alter the list.

Top module: `wr_heat_tracker`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `mig_req` is 0. Reset empties every slot, so an address written before reset needs THRESH fresh writes to fire.
- R2: A write hit to a tracked address raises its count by one. When the count reaches THRESH (default 4), `mig_req` is 1 in the cycle after that write, and `mig_addr` holds the written address.
- R3: A write hit to an untracked address fills a free slot with a count of 1, and the lowest-numbered free slot is used. An address is never held in two slots.
- R4: When every slot is live, a new address replaces the slot whose last write hit is oldest. Every write hit, whether it matches a slot or fills one, makes that slot the most recent.
- R5: An aging step happens in each cycle where `cyc_cnt` equals a deadline. The first deadline is AGE_INTERVAL-1 after reset, and each step moves the deadline on by AGE_INTERVAL. In an aging step every live count drops by one, except the slot that takes a write hit in that same cycle.
- R6: A slot whose count falls to 0 through aging is free and no longer matches its address.
- R7: No request is raised for a write hit with `wr_in_fast` = 1, even when that write reaches THRESH.
- R8: Once a write reaches THRESH, the slot is released whether or not a request went out, so the next write to that address starts again at a count of 1.
- R9: `rd_hit` has no effect on any count, slot or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_hit | input | 1 | Write-hit strobe, one per cycle |
| wr_addr | input | AW | Block address of the write hit |
| wr_in_fast | input | 1 | The hit block already lies in the fast-write region |
| rd_hit | input | 1 | Read-hit strobe (has no effect on the table) |
| cyc_cnt | input | CYC_W | Free-running cycle count used for aging |
| mig_req | output | 1 | Registered one-cycle migration request |
| mig_addr | output | AW | Address that goes with `mig_req` |

## Verification
The hardest case to reach from the ports is replacement of the least recently used slot. The list must first be filled with sixteen distinct addresses, and one early entry must then be refreshed so that it is no longer the oldest. After that, which slot was evicted can only be told from how many further writes each address needs before it fires. The bench fills the list, refreshes the first address and inserts a seventeenth. It then counts writes to the evicted address and to the refreshed one up to their requests. Aging and slot release are reached in a similar way: the bench places `cyc_cnt` on the computed deadline and then counts the writes needed to reach THRESH.

// File: rtl/wht_pkg.sv
package wht_pkg;
  // Action taken for a write hit in one cycle
  typedef enum logic [1:0] {
    WACT_IDLE   = 2'd0,
    WACT_BUMP   = 2'd1,
    WACT_CLAIM  = 2'd2,
    WACT_EVICT  = 2'd3
  } wact_e;
endpackage

// File: rtl/wht_age_timer.sv
module wht_age_timer #(
  parameter int CYC_W    = 32,
  parameter int INTERVAL = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CYC_W-1:0] cyc_cnt,
  output logic             tick
);
  localparam logic [CYC_W-1:0] STEP  = CYC_W'(INTERVAL);
  localparam logic [CYC_W-1:0] FIRST = CYC_W'(INTERVAL - 1);

  logic [CYC_W-1:0] deadline_q;

  assign tick = (cyc_cnt == deadline_q);

  always_ff @(posedge clk) begin
    if (rst)       deadline_q <= FIRST;
    else if (tick) deadline_q <= deadline_q + STEP;
  end

  // After a step the deadline moves on, so the same count cannot fire twice running
  assert_deadline_moves_R5: assert property (@(posedge clk) disable iff (rst)
    tick |=> (deadline_q == $past(deadline_q) + STEP));
endmodule

// File: rtl/wht_match.sv
module wht_match #(
  parameter int N  = 16,
  parameter int AW = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]         live,
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [AW-1:0]        addr,
  output logic                 hit,
  output logic [IW-1:0]        hit_idx,
  output logic                 has_free,
  output logic [IW-1:0]        free_idx
);
  logic [N-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign eq[g] = live[g] && (tags[g] == addr);
    end
  endgenerate

  always_comb begin
    hit     = |eq;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (eq[i]) hit_idx = IW'(i);
  end

  always_comb begin
    has_free = ~&live;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!live[i]) free_idx = IW'(i);
  end
endmodule

// File: rtl/wht_lru.sv
module wht_lru #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  localparam logic [IW-1:0] OLDEST = IW'(N - 1);

  // rank 0 = most recent, N-1 = oldest; ranks stay a permutation
  logic [N-1:0][IW-1:0] rank_q;
  logic [N-1:0]         is_old;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_rank
      assign is_old[g] = (rank_q[g] == OLDEST);
      always_ff @(posedge clk) begin
        if (rst) begin
          rank_q[g] <= IW'(g);
        end else if (touch) begin
          if (IW'(g) == touch_idx)
            rank_q[g] <= '0;
          else if (rank_q[g] < rank_q[touch_idx])
            rank_q[g] <= rank_q[g] + 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++)
      if (is_old[i]) victim_idx = IW'(i);
  end

  // Exactly one slot is oldest at all times
  assert_single_victim_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot(is_old));
  // A touched slot becomes most recent
  assert_touch_to_front_R4: assert property (@(posedge clk) disable iff (rst)
    touch |=> (rank_q[$past(touch_idx)] == '0));
endmodule

// File: rtl/wr_heat_tracker.sv
module wr_heat_tracker
  import wht_pkg::*;
#(
  parameter int N            = 16,
  parameter int AW           = 16,
  parameter int CYC_W        = 32,
  parameter int THRESH       = 4,
  parameter int AGE_INTERVAL = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [AW-1:0]    wr_addr,
  input  logic             wr_in_fast,
  input  logic             rd_hit,
  input  logic [CYC_W-1:0] cyc_cnt,
  output logic             mig_req,
  output logic [AW-1:0]    mig_addr
);
  localparam int IW    = $clog2(N);
  localparam int CNT_W = $clog2(THRESH + 1);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [N-1:0][AW-1:0]    tag_q;
  logic [N-1:0][CNT_W-1:0] cnt_q;
  logic [N-1:0]            live;

  logic          tick;
  logic          hit, has_free;
  logic [IW-1:0] hit_idx, free_idx, victim_idx, sel_idx;
  logic [CNT_W-1:0] next_cnt;
  logic          fire;
  wact_e         wact;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_live
      assign live[g] = (cnt_q[g] != '0);
    end
  endgenerate

  wht_age_timer #(.CYC_W(CYC_W), .INTERVAL(AGE_INTERVAL)) u_age (
    .clk(clk), .rst(rst), .cyc_cnt(cyc_cnt), .tick(tick)
  );

  wht_match #(.N(N), .AW(AW)) u_match (
    .live(live), .tags(tag_q), .addr(wr_addr),
    .hit(hit), .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx)
  );

  wht_lru #(.N(N)) u_lru (
    .clk(clk), .rst(rst), .touch(wr_hit), .touch_idx(sel_idx),
    .victim_idx(victim_idx)
  );

  // Choose the slot and new count for this cycle's write
  always_comb begin
    if (!wr_hit)       wact = WACT_IDLE;
    else if (hit)      wact = WACT_BUMP;
    else if (has_free) wact = WACT_CLAIM;
    else               wact = WACT_EVICT;

    unique case (wact)
      WACT_BUMP:  sel_idx = hit_idx;
      WACT_CLAIM: sel_idx = free_idx;
      WACT_EVICT: sel_idx = victim_idx;
      default:    sel_idx = '0;
    endcase

    next_cnt = (wact == WACT_BUMP) ? cnt_q[hit_idx] + 1'b1 : CNT_ONE;
    fire     = wr_hit && (next_cnt == CNT_FIRE);
  end

  generate
    for (g = 0; g < N; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q[g] <= '0;
          tag_q[g] <= '0;
        end else if (wr_hit && (sel_idx == IW'(g))) begin
          tag_q[g] <= wr_addr;
          cnt_q[g] <= fire ? '0 : next_cnt;
        end else if (tick && live[g]) begin
          cnt_q[g] <= cnt_q[g] - 1'b1;
        end
      end

      // A count never rests at or above the threshold
      assert_count_below_fire_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q[g] < CNT_FIRE);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mig_req  <= 1'b0;
      mig_addr <= '0;
    end else begin
      mig_req <= fire && !wr_in_fast;
      if (fire) mig_addr <= wr_addr;
    end
  end

  // At most one slot matches any address
  assert_no_duplicate_R3: assert property (@(posedge clk) disable iff (rst)
    wr_hit |-> $onehot0(u_match.eq));
  // A request only follows a write hit outside the fast region
  assert_req_after_slow_write_R7: assert property (@(posedge clk) disable iff (rst)
    mig_req |-> $past(wr_hit && !wr_in_fast));
  // The request carries the address written one cycle earlier
  assert_req_addr_R2: assert property (@(posedge clk) disable iff (rst)
    mig_req |-> (mig_addr == $past(wr_addr)));
  // A cycle with only a read hit never leads to a request
  assert_read_inert_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !wr_hit) |=> !mig_req);
  // A cleared slot stays cleared while nothing writes it
  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && !live[0]) |=> !live[0]);
endmodule

// File: tb/sim_wr_heat_tracker.sv
module sim_wr_heat_tracker;
  localparam int AW = 16;
  localparam int CYC_W = 32;
  localparam int IVL = 50;
  localparam int NV = 36;
  // fields: req[44:41] wr[40] rd[39] fast[38] tick[37] addr[36:21] exp_req[20] pad[19:16] exp_addr[15:0]
  localparam logic [44:0] VEC [NV] = '{
    // R2 / R9: three writes, two reads, fourth write fires
    {4'd2, 4'b1000, 16'h0100, 1'b0, 4'h0, 16'h0000},
    {4'd2, 4'b1000, 16'h0100, 1'b0, 4'h0, 16'h0000},
    {4'd2, 4'b1000, 16'h0100, 1'b0, 4'h0, 16'h0000},
    {4'd9, 4'b0100, 16'h0100, 1'b0, 4'h0, 16'h0000},
    {4'd9, 4'b0100, 16'h0100, 1'b0, 4'h0, 16'h0000},
    {4'd2, 4'b1000, 16'h0100, 1'b1, 4'h0, 16'h0100},
    // R8: restart at one after a request
    {4'd8, 4'b1000, 16'h0100, 1'b0, 4'h0, 16'h0000},
    {4'd8, 4'b1000, 16'h0100, 1'b0, 4'h0, 16'h0000},
    {4'd8, 4'b1000, 16'h0100, 1'b0, 4'h0, 16'h0000},
    {4'd8, 4'b1000, 16'h0100, 1'b1, 4'h0, 16'h0100},
    // R7: fast-region block never requests, slot still released
    {4'd7, 4'b1010, 16'h0200, 1'b0, 4'h0, 16'h0000},
    {4'd7, 4'b1010, 16'h0200, 1'b0, 4'h0, 16'h0000},
    {4'd7, 4'b1010, 16'h0200, 1'b0, 4'h0, 16'h0000},
    {4'd7, 4'b1010, 16'h0200, 1'b0, 4'h0, 16'h0000},
    {4'd8, 4'b1000, 16'h0200, 1'b0, 4'h0, 16'h0000},
    {4'd8, 4'b1000, 16'h0200, 1'b0, 4'h0, 16'h0000},
    {4'd8, 4'b1000, 16'h0200, 1'b0, 4'h0, 16'h0000},
    {4'd8, 4'b1000, 16'h0200, 1'b1, 4'h0, 16'h0200},
    // R5: count 3, two aging steps leave 1
    {4'd5, 4'b1000, 16'h0300, 1'b0, 4'h0, 16'h0000},
    {4'd5, 4'b1000, 16'h0300, 1'b0, 4'h0, 16'h0000},
    {4'd5, 4'b1000, 16'h0300, 1'b0, 4'h0, 16'h0000},
    {4'd5, 4'b0001, 16'h0000, 1'b0, 4'h0, 16'h0000},
    {4'd5, 4'b0001, 16'h0000, 1'b0, 4'h0, 16'h0000},
    {4'd5, 4'b1000, 16'h0300, 1'b0, 4'h0, 16'h0000},
    {4'd5, 4'b1000, 16'h0300, 1'b0, 4'h0, 16'h0000},
    {4'd5, 4'b1000, 16'h0300, 1'b1, 4'h0, 16'h0300},
    // R6: aging to zero frees the slot
    {4'd6, 4'b1000, 16'h0400, 1'b0, 4'h0, 16'h0000},
    {4'd6, 4'b0001, 16'h0000, 1'b0, 4'h0, 16'h0000},
    {4'd6, 4'b1000, 16'h0400, 1'b0, 4'h0, 16'h0000},
    {4'd6, 4'b1000, 16'h0400, 1'b0, 4'h0, 16'h0000},
    {4'd6, 4'b1000, 16'h0400, 1'b0, 4'h0, 16'h0000},
    {4'd6, 4'b1000, 16'h0400, 1'b1, 4'h0, 16'h0400},
    // R5: the slot written during an aging step is not decremented
    {4'd5, 4'b1000, 16'h0500, 1'b0, 4'h0, 16'h0000},
    {4'd5, 4'b1000, 16'h0500, 1'b0, 4'h0, 16'h0000},
    {4'd5, 4'b1001, 16'h0500, 1'b0, 4'h0, 16'h0000},
    {4'd5, 4'b1000, 16'h0500, 1'b1, 4'h0, 16'h0500}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_hit = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic wr_in_fast = 1'b0;
  logic rd_hit = 1'b0;
  logic [CYC_W-1:0] cyc_cnt = '0;
  logic mig_req;
  logic [AW-1:0] mig_addr;

  int n_cmp = 0;
  int n_bad = 0;
  int deadline = IVL - 1;

  always #5 clk = ~clk;

  wr_heat_tracker #(.AW(AW), .CYC_W(CYC_W), .AGE_INTERVAL(IVL)) u0 (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wr_addr(wr_addr),
    .wr_in_fast(wr_in_fast), .rd_hit(rd_hit), .cyc_cnt(cyc_cnt),
    .mig_req(mig_req), .mig_addr(mig_addr)
  );

  task automatic check(input int req, input logic exp_r, input logic [AW-1:0] exp_a);
    n_cmp++;
    if (mig_req !== exp_r || (exp_r && mig_addr !== exp_a)) begin
      n_bad++;
      $display("FAIL R%0d: req=%0b addr=%h expected req=%0b addr=%h",
               req, mig_req, mig_addr, exp_r, exp_a);
    end
  endtask

  // Drive one cycle at a falling edge; outputs are read at the next falling edge
  task automatic step(input logic w, input logic r, input logic f, input logic t,
                      input logic [AW-1:0] a);
    wr_hit = w; rd_hit = r; wr_in_fast = f; wr_addr = a;
    if (t) begin
      cyc_cnt = CYC_W'(deadline);
      deadline += IVL;
    end else begin
      cyc_cnt = '0;
    end
    @(negedge clk);
    wr_hit = 1'b0; rd_hit = 1'b0; wr_in_fast = 1'b0; cyc_cnt = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    deadline = IVL - 1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    check(1, 1'b0, '0); // R1: idle after reset

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][40], VEC[i][39], VEC[i][38], VEC[i][37], VEC[i][36:21]);
      check(int'(VEC[i][44:41]), VEC[i][20], VEC[i][15:0]);
    end

    // R1: reset clears a nearly hot entry
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0700);
    rst = 1'b1;
    @(negedge clk);
    check(1, 1'b0, '0);
    @(negedge clk);
    rst = 1'b0;
    deadline = IVL - 1;
    step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0700);
    check(1, 1'b0, '0);

    // R3 / R4: fill all slots, refresh the first, insert a new address
    do_reset();
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, 16'h1000 + 16'(i));
      check(3, 1'b0, '0);
    end
    step(1'b1, 1'b0, 1'b0, 1'b0, 16'h1000);   // count 2, now most recent
    check(4, 1'b0, '0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 16'h2000);   // evicts 0x1001
    check(4, 1'b0, '0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, 16'h1001);
      check(4, 1'b0, '0);                   // restarted at 1, so no fire yet
    end
    step(1'b1, 1'b0, 1'b0, 1'b0, 16'h1001);
    check(4, 1'b1, 16'h1001);
    step(1'b1, 1'b0, 1'b0, 1'b0, 16'h1000);   // kept: 3
    check(4, 1'b0, '0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 16'h1000);   // 4
    check(4, 1'b1, 16'h1000);

    finish_run();
  end
endmodule